// File: doc/BRIEF.md
# Store-to-Load Distance Monitor

The monitor observes a single stream of retired memory operations, one per cycle at most. Each operation is a load or a store, with a word address and a data value. For every load it reports two distances, both counted in memory operations rather than in clock cycles. The access distance reaches back to the most recent store to the same address. The value distance reaches back to the first store of the current run of consecutive equal-value stores to that address. It also raises a flag when the load is a good candidate to be speculated ahead of those stores.

Repeated stores of an identical value do not move the run start. A load may therefore be hoisted past every store of such a run except the first, as long as violation detection compares values. The monitor keeps a small direct-mapped table of recently stored addresses. Each tracked address keeps two operation timestamps and its last stored value. Distances are differences of 16-bit operation timestamps. An address that is not tracked reports an infinite distance.

Top module: `stld_dist_mon`

## Requirements
- R1: Every accepted operation (op_valid high, load or store) advances an operation count by one, and a cycle without op_valid does not. A distance is the difference of operation positions, so a load accepted as the very next operation after a store to the same address reports distance 1, with idle cycles between them not counted.
- R2: A load that hits a tracked address reports res_acc_dist equal to the number of operations from the latest store to that address, modulo 2^16. Loads do not change the tracked state.
- R3: A store that hits a tracked address and writes the same value as that address's last stored value leaves the run start unchanged. A later load then reports res_val_dist measured to the first store of the equal-value run, while res_acc_dist is measured to the latest store.
- R4: A store that writes a value different from the tracked value restarts the run, so a load after it reports res_val_dist equal to res_acc_dist.
- R5: A load to an address that is not tracked reports res_acc_dist = res_val_dist = 16'hFFFF and res_candidate = 1. An untracked address is one never stored, evicted, or stored before reset.
- R6: The table is direct-mapped on address bits [3:0] with the remaining bits as tag. A store to a different address with the same low bits evicts the previous address, and a store that misses always starts a new run, whatever its value.
- R7: For a load, res_candidate is 1 exactly when res_val_dist is greater than or equal to spec_thresh, sampled in the cycle the load is accepted.
- R8: Each load's results appear in the cycle after it is accepted, with res_valid high for exactly that one cycle. Stores and idle cycles produce res_valid = 0.
- R9: A synchronous active-high reset clears every tracked entry, restarts the operation count and forces res_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | A memory operation is presented this cycle |
| op_is_store | input | 1 | 1 = store, 0 = load |
| op_addr | input | 32 | Word address of the operation |
| op_data | input | 32 | Value written by a store (ignored for loads) |
| spec_thresh | input | 16 | Minimum value distance for a speculation candidate |
| res_valid | output | 1 | Load result strobe, one cycle after the load |
| res_acc_dist | output | 16 | Operations since the latest store to the address |
| res_val_dist | output | 16 | Operations since the start of the equal-value store run |
| res_candidate | output | 1 | Load may be speculated ahead of the stores |

## Verification
Directed sequences first separate the two distances. Runs of identical stores must leave the value distance anchored while the access distance follows the latest store, and a changed value must make them equal again. Idle gaps between a store and a load show that cycles are not counted. Aliasing pairs on the same low address bits show eviction, including a re-store of an identical value after eviction restarting the run. A threshold sweep around the exact distance pins the comparison boundary. A long random mix over a small address set, compared on every clock against a behavioural model, exercises hits, misses and evictions interleaved with back-to-back loads.

// File: rtl/stld_pkg.sv
package stld_pkg;

    // width of operation timestamps and reported distances
    parameter int TS_W = 16;

    // distance reported for an address with no tracked store
    localparam logic [TS_W-1:0] DIST_INF = '1;

    typedef logic [TS_W-1:0] ts_t;

    typedef struct packed {
        ts_t  acc;
        ts_t  vdist;
        logic cand;
    } load_res_t;

    // modulo distance between two timestamps
    function automatic ts_t ts_gap(input ts_t now, input ts_t then);
        return now - then;
    endfunction

endpackage

// File: rtl/stld_op_counter.sv
module stld_op_counter
    import stld_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output ts_t  count
);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (adv) begin
            count <= count + ts_t'(1);
        end
    end

endmodule

// File: rtl/stld_dist_table.sv
module stld_dist_table
    import stld_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int ENTRIES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic              op_is_store,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] op_data,
    input  ts_t               now_ts,
    output logic              lk_hit,
    output ts_t               lk_last_ts,
    output ts_t               lk_run_ts
);

    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q  [ENTRIES];
    ts_t                last_q [ENTRIES];
    ts_t                run_q  [ENTRIES];
    logic [DATA_W-1:0]  val_q  [ENTRIES];

    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;
    logic             same_val;
    logic             store_fire;
    logic [ENTRIES-1:0] wr_sel;

    assign idx        = op_addr[IDX_W-1:0];
    assign tag        = op_addr[ADDR_W-1:IDX_W];
    assign lk_hit     = valid_q[idx] && (tag_q[idx] == tag);
    assign same_val   = lk_hit && (val_q[idx] == op_data);
    assign store_fire = op_valid && op_is_store;
    assign lk_last_ts = last_q[idx];
    assign lk_run_ts  = run_q[idx];

    // one-hot write select, one decoder slice per entry
    for (genvar e = 0; e < ENTRIES; e++) begin : g_sel
        assign wr_sel[e] = store_fire && (idx == IDX_W'(e));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else begin
            for (int e = 0; e < ENTRIES; e++) begin
                if (wr_sel[e]) begin
                    valid_q[e] <= 1'b1;
                    tag_q[e]   <= tag;
                    last_q[e]  <= now_ts;
                    val_q[e]   <= op_data;
                    if (!same_val) begin
                        run_q[e] <= now_ts;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/stld_result_stage.sv
module stld_result_stage
    import stld_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load_fire,
    input  logic      hit,
    input  ts_t       last_ts,
    input  ts_t       run_ts,
    input  ts_t       now_ts,
    input  ts_t       thresh,
    output logic      res_valid,
    output load_res_t res
);

    load_res_t nxt;

    always_comb begin
        if (hit) begin
            nxt.acc   = ts_gap(now_ts, last_ts);
            nxt.vdist = ts_gap(now_ts, run_ts);
            nxt.cand  = (nxt.vdist >= thresh);
        end else begin
            nxt.acc   = DIST_INF;
            nxt.vdist = DIST_INF;
            nxt.cand  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
        end else begin
            res_valid <= load_fire;
        end
    end

    always_ff @(posedge clk) begin
        if (load_fire) begin
            res <= nxt;
        end
    end

endmodule

// File: rtl/stld_dist_mon.sv
module stld_dist_mon
    import stld_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int ENTRIES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic              op_is_store,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] op_data,
    input  logic [TS_W-1:0]   spec_thresh,
    output logic              res_valid,
    output logic [TS_W-1:0]   res_acc_dist,
    output logic [TS_W-1:0]   res_val_dist,
    output logic              res_candidate
);

    ts_t       op_count;
    logic      lk_hit;
    ts_t       lk_last_ts;
    ts_t       lk_run_ts;
    load_res_t res;
    logic      load_fire;

    assign load_fire = op_valid && !op_is_store;

    stld_op_counter u_cnt (
        .clk   (clk),
        .rst   (rst),
        .adv   (op_valid),
        .count (op_count)
    );

    stld_dist_table #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .ENTRIES (ENTRIES)
    ) u_tab (
        .clk         (clk),
        .rst         (rst),
        .op_valid    (op_valid),
        .op_is_store (op_is_store),
        .op_addr     (op_addr),
        .op_data     (op_data),
        .now_ts      (op_count),
        .lk_hit      (lk_hit),
        .lk_last_ts  (lk_last_ts),
        .lk_run_ts   (lk_run_ts)
    );

    stld_result_stage u_res (
        .clk       (clk),
        .rst       (rst),
        .load_fire (load_fire),
        .hit       (lk_hit),
        .last_ts   (lk_last_ts),
        .run_ts    (lk_run_ts),
        .now_ts    (op_count),
        .thresh    (spec_thresh),
        .res_valid (res_valid),
        .res       (res)
    );

    assign res_acc_dist  = res.acc;
    assign res_val_dist  = res.vdist;
    assign res_candidate = res.cand;

endmodule

// File: rtl/stld_dist_mon_chk.sv
module stld_dist_mon_chk
    import stld_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      op_valid,
    input logic      op_is_store,
    input ts_t       spec_thresh,
    input logic      res_valid,
    input ts_t       res_val_dist,
    input logic      res_candidate,
    input ts_t       op_count
);

    // R8
    load_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_is_store) |=> res_valid);

    // R8
    no_spurious_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !(op_valid && !op_is_store) |=> !res_valid);

    // R7
    cand_thresh_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_is_store) |=>
            (res_candidate == (res_val_dist >= $past(spec_thresh))));

    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> (op_count == ts_t'($past(op_count) + 1'b1)));

    // R1
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable(op_count));

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!res_valid && (op_count == '0)));

endmodule

bind stld_dist_mon stld_dist_mon_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .op_valid      (op_valid),
    .op_is_store   (op_is_store),
    .spec_thresh   (spec_thresh),
    .res_valid     (res_valid),
    .res_val_dist  (res_val_dist),
    .res_candidate (res_candidate),
    .op_count      (op_count)
);

// File: tb/stld_dist_mon_bench.sv
module stld_dist_mon_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic        op_is_store = 1'b0;
    logic [31:0] op_addr = '0;
    logic [31:0] op_data = '0;
    logic [15:0] spec_thresh = '0;
    logic        res_valid;
    logic [15:0] res_acc_dist;
    logic [15:0] res_val_dist;
    logic        res_candidate;

    always #4 clk = ~clk;

    stld_dist_mon u_stld_dist_mon (
        .clk           (clk),
        .rst           (rst),
        .op_valid      (op_valid),
        .op_is_store   (op_is_store),
        .op_addr       (op_addr),
        .op_data       (op_data),
        .spec_thresh   (spec_thresh),
        .res_valid     (res_valid),
        .res_acc_dist  (res_acc_dist),
        .res_val_dist  (res_val_dist),
        .res_candidate (res_candidate)
    );

    int    total = 0;
    int    bad   = 0;
    bit    done  = 0;
    string cur_tag = "R9";

    // behavioural model state
    int           pos;
    int           lpos [logic [31:0]];
    int           rpos [logic [31:0]];
    logic [31:0]  lval [logic [31:0]];
    logic [31:0]  owner [16];
    bit           used  [16];
    bit           pend_v;
    logic [15:0]  pend_acc, pend_val;
    bit           pend_cand;

    task automatic check(input string tag, input string what,
                         input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
        end
    endtask

    task automatic model_clear();
        pos = 0;
        pend_v = 0;
        for (int i = 0; i < 16; i++) used[i] = 0;
    endtask

    task automatic step(input bit v, input bit st, input logic [31:0] a,
                        input logic [31:0] d, input logic [15:0] thr);
        int  slot;
        bit  hit;
        @(negedge clk);
        // outputs of the previous cycle
        check("R8", "res_valid", {15'd0, res_valid}, {15'd0, pend_v});
        if (pend_v) begin
            check(cur_tag, "acc_dist", res_acc_dist, pend_acc);
            check(cur_tag, "val_dist", res_val_dist, pend_val);
            check(cur_tag, "candidate", {15'd0, res_candidate}, {15'd0, pend_cand});
        end
        op_valid    = v;
        op_is_store = st;
        op_addr     = a;
        op_data     = d;
        spec_thresh = thr;
        pend_v      = v && !st;
        if (v) begin
            slot = int'(a[3:0]);
            hit  = used[slot] && (owner[slot] == a);
            if (!st) begin
                if (hit) begin
                    pend_acc  = 16'((pos - lpos[a]) & 16'hFFFF);
                    pend_val  = 16'((pos - rpos[a]) & 16'hFFFF);
                    pend_cand = (pend_val >= thr);
                end else begin
                    pend_acc  = 16'hFFFF;
                    pend_val  = 16'hFFFF;
                    pend_cand = 1'b1;
                end
            end else begin
                if (!hit || lval[a] != d) rpos[a] = pos;
                lpos[a]     = pos;
                lval[a]     = d;
                owner[slot] = a;
                used[slot]  = 1;
            end
            pos++;
        end
    endtask

    task automatic st_op(input logic [31:0] a, input logic [31:0] d);
        step(1, 1, a, d, 16'd0);
    endtask

    task automatic ld_op(input logic [31:0] a, input logic [15:0] thr);
        step(1, 0, a, 32'hDEAD_BEEF, thr);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, '0, '0, '0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        op_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        model_clear();
        // R9: reset state, no result strobe, misses everywhere
        cur_tag = "R9";
        do_reset();
        idle(2);
        ld_op(32'h0000_0100, 16'd0);

        // R2: plain access distance with unrelated traffic between
        cur_tag = "R2";
        st_op(32'h0000_0100, 32'd5);
        st_op(32'h0000_0101, 32'd1);
        st_op(32'h0000_0102, 32'd2);
        ld_op(32'h0000_0103, 16'd0);
        ld_op(32'h0000_0100, 16'd0);
        ld_op(32'h0000_0100, 16'd0);

        // R1: idle cycles do not count, adjacent store then load is 1
        cur_tag = "R1";
        st_op(32'h0000_0204, 32'd9);
        idle(5);
        ld_op(32'h0000_0204, 16'd1);
        idle(3);
        ld_op(32'h0000_0204, 16'd2);

        // R3: equal-value stores keep the run start
        cur_tag = "R3";
        st_op(32'h0000_0305, 32'd7);
        st_op(32'h0000_0306, 32'd0);
        st_op(32'h0000_0305, 32'd7);
        idle(2);
        st_op(32'h0000_0305, 32'd7);
        ld_op(32'h0000_0305, 16'd0);
        ld_op(32'h0000_0305, 16'd4);

        // R4: a different value restarts the run
        cur_tag = "R4";
        st_op(32'h0000_0305, 32'd8);
        ld_op(32'h0000_0305, 16'd0);
        st_op(32'h0000_0305, 32'd8);
        st_op(32'h0000_0305, 32'd9);
        ld_op(32'h0000_0305, 16'd0);

        // R5: untracked addresses report infinite distance
        cur_tag = "R5";
        ld_op(32'h0000_0F07, 16'hFFFF);
        ld_op(32'h0001_0305, 16'd3);

        // R6: aliasing on the low address bits evicts
        cur_tag = "R6";
        st_op(32'h0000_0200, 32'd1);
        st_op(32'h0000_0210, 32'd1);
        ld_op(32'h0000_0200, 16'd0);
        ld_op(32'h0000_0210, 16'd0);
        st_op(32'h0000_0200, 32'd1);
        st_op(32'h0000_0200, 32'd1);
        ld_op(32'h0000_0200, 16'd0);
        ld_op(32'h0000_0210, 16'd0);

        // R7: threshold boundary around the exact value distance
        cur_tag = "R7";
        st_op(32'h0000_0408, 32'd3);
        idle(1);
        ld_op(32'h0000_0408, 16'd0);   // distance 1
        ld_op(32'h0000_0408, 16'd2);   // distance 2, equal
        ld_op(32'h0000_0408, 16'd4);   // distance 3, below
        ld_op(32'h0000_0408, 16'd3);   // distance 4, above
        ld_op(32'h0000_0408, 16'hFFFF);

        // R8: back-to-back loads, each one strobed
        cur_tag = "R8";
        for (int i = 0; i < 6; i++) ld_op(32'h0000_0408 + 32'(i % 2), 16'd5);
        idle(2);

        // R2: random mix over a small address set
        cur_tag = "R2";
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            a = {26'd0, 2'($urandom_range(0, 3)), 4'($urandom_range(0, 15))};
            case ($urandom_range(0, 3))
                0: idle(1);
                1: st_op(a, 32'($urandom_range(0, 2)));
                default: ld_op(a, 16'($urandom_range(0, 40)));
            endcase
        end
        idle(2);

        // R9: reset drops every tracked entry
        st_op(32'h0000_050A, 32'd4);
        idle(1);
        cur_tag = "R9";
        do_reset();
        ld_op(32'h0000_050A, 16'd0);
        idle(2);

        finish_run();
    end

endmodule